// File: doc/BRIEF.md
# Dual Wiper Register Controller

This block keeps the control state for two digitally set resistor wipers and exposes it through a byte-oriented register port. It is meant to sit behind an I2C slave front end. The front end reports bus START and STOP events as single-cycle pulses and hands over every byte it receives. The block answers each byte with an acknowledge decision and, for reads, a data byte. Each channel has a volatile wiper register that alone drives a 7-bit tap select (128 taps, codes 0x00 to 0x7F). Each channel also has a non-volatile initial value, modelled as a register cell that keeps its contents across a warm reset.

After any reset the block copies both initial values into the wipers before it accepts a byte. Writes to an initial value are only staged while the transaction runs. The self-timed commit starts at the STOP that closes the transaction and lasts a fixed number of cycles, and a busy flag is raised for that time. A shutdown input parks both tap outputs at code 0 for low-power operation, while the wiper contents are kept.

Byte transfer uses valid/ready. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only during the one recall cycle after reset. The reply is not back-pressured: it appears as a one-cycle `rsp_valid` pulse on the cycle after acceptance, and the front end must capture it then. No byte may be offered in a cycle that carries `bus_start` or `bus_stop`.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: On release of reset, `in_ready` is low for one cycle while each wiper is loaded from its initial value, and `in_ready` then goes high. `rst_n` leaves the initial values untouched. `por_n` also restores both initial values to `INIT_CODE`.
- R2: The register pointer byte selects 0 = wiper 0, 1 = wiper 1, 2 = initial value 0 and 3 = initial value 1. Any pointer of 4 or above is answered with no acknowledge, as is every later byte of that transaction, and no register changes.
- R3: Only bits 6..0 of a data byte are stored. Bit 7 is dropped, and read data always returns bit 7 as 0.
- R4: A data byte written to a wiper changes that channel's tap on the edge that accepts it. It leaves the other channel unchanged and starts no non-volatile cycle.
- R5: The first byte after START is {DEV_ID[3:0], select[2:0], dir} with dir = 1 meaning read. A mismatch is not acknowledged, and neither is any later byte up to STOP.
- R6: The three address-select inputs are captured at START. Changes during the transaction do not affect address matching.
- R7: A write to an initial value is held until STOP. `nv_busy` rises on the cycle after STOP and stays high for exactly `NV_WRITE_CYCLES` cycles. The new value is readable after that, and the wiper is not changed.
- R8: While `nv_busy` is high, every byte is answered with no acknowledge and no register, including staged values, changes.
- R9: While `shutdown` is high both taps read 0. Wiper writes still land, and when shutdown is released the taps show the stored wiper codes.
- R10: Each accepted byte yields exactly one `rsp_valid` pulse on the next cycle. A read returns the register at the pointer set by the last pointer byte, which persists across a repeated START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; also reinitialises the non-volatile cells |
| rst_n | input | 1 | Warm reset, active low; triggers recall |
| addr_sel | input | 3 | Address-select inputs, low bits of the device address |
| bus_start | input | 1 | One-cycle pulse for START or repeated START |
| bus_stop | input | 1 | One-cycle pulse for STOP |
| in_valid | input | 1 | Received byte is valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Received byte |
| rsp_valid | output | 1 | Reply for the byte taken in the previous cycle |
| rsp_ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rsp_data | output | 8 | Read data for read-phase bytes, else 0 |
| shutdown | input | 1 | Low-power request; taps parked at 0 |
| nv_busy | output | 1 | Non-volatile commit in progress |
| tap_code | output | 14 | Tap codes, channel 0 in bits 6..0, channel 1 in bits 13..7 |

## Verification
Two functions can act on the same edge: a wiper write accepted from the byte port and the release of shutdown. The bench drives the last data byte of a wiper write in the same cycle that it drops `shutdown`. It then expects the new code on that tap right after the edge, while the other tap shows its preserved value. The second overlap is a transaction that arrives during the commit window. The bench sends one inside the window and judges it by the missing acknowledges, by the unchanged taps and by the initial value read back once busy clears.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  localparam int TAP_W    = 7;
  localparam int NUM_CH   = 2;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int NUM_REGS = 2 * NUM_CH;
  localparam int PTR_W    = $clog2(NUM_REGS);
  localparam int BYTE_W   = 8;
  localparam int SEL_W    = 3;
  localparam int ID_W     = BYTE_W - 1 - SEL_W;

  typedef logic [TAP_W-1:0] tap_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_PTR,
    PH_WR,
    PH_RD,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/dwc_reg_port.sv
module dwc_reg_port
  import dwc_pkg::*;
#(
  parameter logic [ID_W-1:0] DEV_ID = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_open,
  input  logic [SEL_W-1:0]  addr_sel,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              busy,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  tap_t              reg_view [NUM_REGS],
  output logic              in_ready,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_ptr,
  output tap_t              wr_code,
  output logic              rsp_valid,
  output logic              rsp_ack,
  output logic [BYTE_W-1:0] rsp_data
);
  phase_e              phase_q, phase_n;
  logic [SEL_W-1:0]    sel_q;
  logic [PTR_W-1:0]    ptr_q, ptr_n;
  logic                accept, ack_c;
  logic [BYTE_W-1:0]   data_c;

  assign in_ready = port_open;
  assign accept   = in_valid && port_open;
  assign wr_ptr   = ptr_q;
  assign wr_code  = in_data[TAP_W-1:0];

  always_comb begin
    phase_n = phase_q;
    ptr_n   = ptr_q;
    ack_c   = 1'b0;
    data_c  = '0;
    wr_en   = 1'b0;
    unique case (phase_q)
      PH_DEV: begin
        if (!busy && in_data[BYTE_W-1:1] == {DEV_ID, sel_q}) begin
          ack_c   = 1'b1;
          phase_n = in_data[0] ? PH_RD : PH_PTR;
        end else begin
          phase_n = PH_SKIP;
        end
      end
      PH_PTR: begin
        if (in_data[BYTE_W-1:PTR_W] == '0) begin
          ack_c   = 1'b1;
          ptr_n   = in_data[PTR_W-1:0];
          phase_n = PH_WR;
        end else begin
          phase_n = PH_SKIP;
        end
      end
      PH_WR: begin
        ack_c = 1'b1;
        wr_en = accept;
      end
      PH_RD: begin
        ack_c  = 1'b1;
        data_c = {{(BYTE_W-TAP_W){1'b0}}, reg_view[ptr_q]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      sel_q     <= '0;
      ptr_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_ack  <= ack_c;
        rsp_data <= data_c;
      end
      if (bus_start) begin
        sel_q   <= addr_sel;
        phase_q <= PH_DEV;
      end else if (bus_stop) begin
        phase_q <= PH_IDLE;
      end else if (accept) begin
        phase_q <= phase_n;
        ptr_q   <= ptr_n;
      end
    end
  end
endmodule

// File: rtl/dwc_nv_store.sv
module dwc_nv_store
  import dwc_pkg::*;
#(
  parameter int   NV_WRITE_CYCLES = 40,
  parameter tap_t INIT_CODE       = 7'h40
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_n,
  input  logic            stage_en,
  input  logic [CH_W-1:0] stage_ch,
  input  tap_t            stage_code,
  input  logic            commit_go,
  output tap_t            nv_q [NUM_CH],
  output logic            busy
);
  localparam int CNT_W = $clog2(NV_WRITE_CYCLES + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [NUM_CH-1:0] pend_q;
  tap_t              stage_q [NUM_CH];
  logic              fire;

  assign fire = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      if (commit_go && (|pend_q)) begin
        busy  <= 1'b1;
        cnt_q <= CNT_W'(NV_WRITE_CYCLES - 1);
      end
    end else if (fire) begin
      busy <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cell
    localparam logic [CH_W-1:0] MY_CH = CH_W'(c);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[c]  <= 1'b0;
        stage_q[c] <= '0;
      end else if (stage_en && stage_ch == MY_CH) begin
        pend_q[c]  <= 1'b1;
        stage_q[c] <= stage_code;
      end else if (fire) begin
        pend_q[c]  <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        nv_q[c] <= INIT_CODE;
      end else if (fire && pend_q[c]) begin
        nv_q[c] <= stage_q[c];
      end
    end
  end
endmodule

// File: rtl/dwc_wiper_bank.sv
module dwc_wiper_bank
  import dwc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  tap_t             nv_q [NUM_CH],
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  tap_t             wr_code,
  output tap_t             wiper_q [NUM_CH],
  output logic             recall_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recall_done <= 1'b0;
    else        recall_done <= 1'b1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_wiper
    localparam logic [CH_W-1:0] MY_CH = CH_W'(c);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wiper_q[c] <= '0;
      end else if (!recall_done) begin
        wiper_q[c] <= nv_q[c];
      end else if (wr_en && !wr_ptr[PTR_W-1] && wr_ptr[CH_W-1:0] == MY_CH) begin
        wiper_q[c] <= wr_code;
      end
    end
  end
endmodule

// File: rtl/dwc_tap_out.sv
module dwc_tap_out
  import dwc_pkg::*;
(
  input  logic                    shutdown,
  input  tap_t                    wiper_q [NUM_CH],
  output logic [NUM_CH*TAP_W-1:0] tap_code
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_tap
    assign tap_code[c*TAP_W +: TAP_W] = shutdown ? '0 : wiper_q[c];
  end
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
  import dwc_pkg::*;
#(
  parameter int              NV_WRITE_CYCLES = 40,
  parameter logic [ID_W-1:0] DEV_ID          = 4'hA,
  parameter tap_t            INIT_CODE       = 7'h40
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    rst_n,
  input  logic [SEL_W-1:0]        addr_sel,
  input  logic                    bus_start,
  input  logic                    bus_stop,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BYTE_W-1:0]       in_data,
  output logic                    rsp_valid,
  output logic                    rsp_ack,
  output logic [BYTE_W-1:0]       rsp_data,
  input  logic                    shutdown,
  output logic                    nv_busy,
  output logic [NUM_CH*TAP_W-1:0] tap_code
);
  logic             sys_rst_n;
  logic             recall_done;
  logic             wr_en;
  logic [PTR_W-1:0] wr_ptr;
  tap_t             wr_code;
  tap_t             nv_q    [NUM_CH];
  tap_t             wiper_q [NUM_CH];
  tap_t             reg_view [NUM_REGS];

  assign sys_rst_n = rst_n & por_n;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_view
    assign reg_view[c]        = wiper_q[c];
    assign reg_view[NUM_CH+c] = nv_q[c];
  end

  dwc_reg_port #(.DEV_ID(DEV_ID)) u_port (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .port_open (recall_done),
    .addr_sel  (addr_sel),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .busy      (nv_busy),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .reg_view  (reg_view),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .wr_code   (wr_code),
    .rsp_valid (rsp_valid),
    .rsp_ack   (rsp_ack),
    .rsp_data  (rsp_data)
  );

  dwc_nv_store #(
    .NV_WRITE_CYCLES (NV_WRITE_CYCLES),
    .INIT_CODE       (INIT_CODE)
  ) u_nv (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n      (sys_rst_n),
    .stage_en   (wr_en && wr_ptr[PTR_W-1]),
    .stage_ch   (wr_ptr[CH_W-1:0]),
    .stage_code (wr_code),
    .commit_go  (bus_stop),
    .nv_q       (nv_q),
    .busy       (nv_busy)
  );

  dwc_wiper_bank u_wiper (
    .clk         (clk),
    .rst_n       (sys_rst_n),
    .nv_q        (nv_q),
    .wr_en       (wr_en),
    .wr_ptr      (wr_ptr),
    .wr_code     (wr_code),
    .wiper_q     (wiper_q),
    .recall_done (recall_done)
  );

  dwc_tap_out u_tap (
    .shutdown (shutdown),
    .wiper_q  (wiper_q),
    .tap_code (tap_code)
  );
endmodule

// File: rtl/dwc_chk.sv
module dwc_chk
  import dwc_pkg::*;
#(
  parameter int NV_WRITE_CYCLES = 40
) (
  input logic                    clk,
  input logic                    por_n,
  input logic                    rst_n,
  input logic                    bus_stop,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    rsp_valid,
  input logic                    rsp_ack,
  input logic                    shutdown,
  input logic                    nv_busy,
  input logic [NUM_CH*TAP_W-1:0] tap_code
);
  localparam int RUN_W = $clog2(NV_WRITE_CYCLES + 2);

  logic [RUN_W-1:0] busy_run;
  logic             rst_any;

  assign rst_any = !rst_n || !por_n;

  always_ff @(posedge clk) begin
    if (rst_any)      busy_run <= '0;
    else if (nv_busy) busy_run <= busy_run + 1'b1;
    else              busy_run <= '0;
  end

  // R10
  rsp_follows_chk: assert property (@(posedge clk) disable iff (rst_any)
    (in_valid && in_ready) |=> rsp_valid);

  // R10
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst_any)
    !(in_valid && in_ready) |=> !rsp_valid);

  // R7
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (rst_any)
    $rose(nv_busy) |-> $past(bus_stop));

  // R7
  busy_bound_chk: assert property (@(posedge clk) disable iff (rst_any)
    busy_run <= RUN_W'(NV_WRITE_CYCLES));

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (rst_any)
    $fell(nv_busy) |-> (busy_run == RUN_W'(NV_WRITE_CYCLES)));

  // R8
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst_any)
    (nv_busy && in_valid && in_ready) |=> !rsp_ack);

  // R9
  shutdown_quiet_chk: assert property (@(posedge clk) disable iff (rst_any)
    shutdown |-> (tap_code == '0));
endmodule

bind dual_wiper_ctrl dwc_chk #(.NV_WRITE_CYCLES(NV_WRITE_CYCLES)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .rst_n     (rst_n),
  .bus_stop  (bus_stop),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .rsp_valid (rsp_valid),
  .rsp_ack   (rsp_ack),
  .shutdown  (shutdown),
  .nv_busy   (nv_busy),
  .tap_code  (tap_code)
);

// File: tb/tb_dual_wiper_ctrl.sv
module tb_dual_wiper_ctrl;
  localparam int       CLK_PERIOD = 10;
  localparam int       NVC        = 40;
  localparam logic [6:0] INIT     = 7'h40;
  localparam logic [2:0] SEL      = 3'b101;
  localparam logic [7:0] DEVW     = {4'hA, SEL, 1'b0};
  localparam logic [7:0] DEVR     = {4'hA, SEL, 1'b1};

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic [2:0]  addr_sel = SEL;
  logic        bus_start = 1'b0, bus_stop = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        shutdown = 1'b0;
  logic        in_ready, rsp_valid, rsp_ack, nv_busy;
  logic [7:0]  rsp_data;
  logic [13:0] tap_code;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  dual_wiper_ctrl #(.NV_WRITE_CYCLES(NVC), .DEV_ID(4'hA), .INIT_CODE(INIT)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .addr_sel(addr_sel),
    .bus_start(bus_start), .bus_stop(bus_stop), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .rsp_valid(rsp_valid),
    .rsp_ack(rsp_ack), .rsp_data(rsp_data), .shutdown(shutdown),
    .nv_busy(nv_busy), .tap_code(tap_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bstart();
    @(negedge clk) bus_start = 1'b1;
    @(negedge clk) bus_start = 1'b0;
  endtask

  task automatic bstop();
    @(negedge clk) bus_stop = 1'b1;
    @(negedge clk) bus_stop = 1'b0;
  endtask

  task automatic put(input logic [7:0] b, output logic ack, output logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 rsp_valid", {15'd0, rsp_valid}, 16'd1);
    ack = rsp_ack;
    d   = rsp_data;
  endtask

  task automatic write_reg(input logic [7:0] ptr, input logic [7:0] val, output logic [2:0] acks);
    logic [7:0] d;
    bstart();
    put(DEVW, acks[2], d);
    put(ptr,  acks[1], d);
    put(val,  acks[0], d);
    bstop();
  endtask

  task automatic read_reg(input logic [7:0] ptr, output logic [7:0] val);
    logic a;
    logic [7:0] d;
    bstart();
    put(DEVW, a, d);
    put(ptr,  a, d);
    bstart();
    put(DEVR, a, d);
    put(8'h00, a, val);
    bstop();
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (nv_busy && cycles < 1000) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic t_power_on();
    por_n = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    check("R1 ready low in recall", {15'd0, in_ready}, 16'd0);
    @(negedge clk);
    check("R1 ready after recall", {15'd0, in_ready}, 16'd1);
    check("R1 taps after power-on", {2'b0, tap_code}, {2'b0, INIT, INIT});
    check("R1 busy idle", {15'd0, nv_busy}, 16'd0);
  endtask

  task automatic t_wiper_write();
    logic [2:0] acks;
    logic [7:0] v;
    write_reg(8'h00, 8'h15, acks);
    check("R4 acks", {13'd0, acks}, 16'h7);
    check("R4 tap0 set, tap1 kept", {2'b0, tap_code}, {2'b0, INIT, 7'h15});
    check("R4 no nv cycle", {15'd0, nv_busy}, 16'd0);
    write_reg(8'h01, 8'hFF, acks);
    check("R3 msb dropped", {9'd0, tap_code[13:7]}, 16'h7F);
    read_reg(8'h01, v);
    check("R3 R10 read wiper1", {8'd0, v}, 16'h7F);
    read_reg(8'h00, v);
    check("R10 read wiper0", {8'd0, v}, 16'h15);
  endtask

  task automatic t_bad_ptr();
    logic a;
    logic [7:0] d, v;
    bstart();
    put(DEVW, a, d);
    check("R2 dev ack", {15'd0, a}, 16'd1);
    put(8'h04, a, d);
    check("R2 ptr 4 nack", {15'd0, a}, 16'd0);
    put(8'h22, a, d);
    check("R2 data after bad ptr nack", {15'd0, a}, 16'd0);
    bstop();
    bstart();
    put(DEVW, a, d);
    put(8'h80, a, d);
    check("R2 ptr 0x80 nack", {15'd0, a}, 16'd0);
    bstop();
    read_reg(8'h00, v);
    check("R2 wiper0 unchanged", {8'd0, v}, 16'h15);
    check("R2 taps unchanged", {2'b0, tap_code}, {2'b0, 7'h7F, 7'h15});
  endtask

  task automatic t_dev_addr();
    logic a;
    logic [7:0] d;
    bstart();
    put({4'hA, 3'b100, 1'b0}, a, d);
    check("R5 wrong select nack", {15'd0, a}, 16'd0);
    put(8'h00, a, d);
    check("R5 rest nack", {15'd0, a}, 16'd0);
    put(8'h09, a, d);
    check("R5 rest nack data", {15'd0, a}, 16'd0);
    bstop();
    check("R5 taps unchanged", {2'b0, tap_code}, {2'b0, 7'h7F, 7'h15});
    bstart();
    addr_sel = 3'b000;
    put(DEVW, a, d);
    check("R6 select latched at start", {15'd0, a}, 16'd1);
    put(8'h00, a, d);
    put(8'h05, a, d);
    bstop();
    addr_sel = SEL;
    check("R6 write landed", {9'd0, tap_code[6:0]}, 16'h05);
  endtask

  task automatic t_nv_write();
    logic [2:0] acks;
    logic [7:0] v;
    int cyc;
    write_reg(8'h02, 8'h2A, acks);
    check("R7 acks", {13'd0, acks}, 16'h7);
    check("R7 busy after stop", {15'd0, nv_busy}, 16'd1);
    wait_idle(cyc);
    check("R7 busy length", cyc[15:0], 16'(NVC));
    check("R7 wiper untouched", {9'd0, tap_code[6:0]}, 16'h05);
    read_reg(8'h02, v);
    check("R7 iv0 committed", {8'd0, v}, 16'h2A);
    read_reg(8'h03, v);
    check("R7 iv1 untouched", {8'd0, v}, {9'd0, INIT});
  endtask

  task automatic t_busy_refuse();
    logic [2:0] acks;
    logic [7:0] v;
    int cyc;
    write_reg(8'h03, 8'h11, acks);
    check("R8 busy started", {15'd0, nv_busy}, 16'd1);
    write_reg(8'h01, 8'h66, acks);
    check("R8 all refused while busy", {13'd0, acks}, 16'h0);
    check("R8 still busy", {15'd0, nv_busy}, 16'd1);
    wait_idle(cyc);
    check("R8 tap1 unchanged", {9'd0, tap_code[13:7]}, 16'h7F);
    read_reg(8'h03, v);
    check("R8 iv1 holds accepted value", {8'd0, v}, 16'h11);
    check("R8 no new nv cycle", {15'd0, nv_busy}, 16'd0);
  endtask

  task automatic t_recall();
    logic [7:0] v;
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 ready low after warm reset", {15'd0, in_ready}, 16'd0);
    @(negedge clk);
    check("R1 recall into wipers", {2'b0, tap_code}, {2'b0, 7'h11, 7'h2A});
    read_reg(8'h02, v);
    check("R1 iv survives warm reset", {8'd0, v}, 16'h2A);
  endtask

  task automatic t_shutdown();
    logic [2:0] acks;
    logic a;
    logic [7:0] d;
    @(negedge clk) shutdown = 1'b1;
    @(negedge clk);
    check("R9 taps parked", {2'b0, tap_code}, 16'h0);
    write_reg(8'h00, 8'h33, acks);
    check("R9 write acked in shutdown", {13'd0, acks}, 16'h7);
    check("R9 taps still parked", {2'b0, tap_code}, 16'h0);
    bstart();
    put(DEVW, a, d);
    put(8'h01, a, d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h44;
    shutdown = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 release with same-edge write", {2'b0, tap_code}, {2'b0, 7'h44, 7'h33});
    bstop();
  endtask

  task automatic t_por();
    logic [7:0] v;
    @(negedge clk) por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check("R1 por restores init", {2'b0, tap_code}, {2'b0, INIT, INIT});
    read_reg(8'h02, v);
    check("R1 iv0 back to init", {8'd0, v}, {9'd0, INIT});
  endtask

  initial begin
    t_power_on();
    t_wiper_write();
    t_bad_ptr();
    t_dev_addr();
    t_nv_write();
    t_busy_refuse();
    t_recall();
    t_shutdown();
    t_por();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule